// File: doc/BRIEF.md
# Bidirectional Serial Word Interface Register

This block sits on the host side of a link between a processor accumulator and a bit-serial storage peripheral. It holds one data word and moves it either way. Toward the peripheral, the accumulator word is loaded in parallel and then sent out one bit at a time, least significant data bit first. An odd parity bit for the outgoing word appears on its own line. Toward the host, bits arrive one at a time and are gathered into a right-aligned word that the host reads in parallel. The peripheral supplies the shift pulses. These pulses are asynchronous, so they are synchronized and edge-detected in the system clock domain.

The block has two word sizes, wide (12 bits) and narrow (8 bits). A mode-set strobe picks one from a chosen accumulator bit. In narrow mode the data occupies the upper eight register bits, and the low four bits are always zero. A direction input chooses the transfer direction. A transfer strobe either loads a word for sending or, when receiving, discards the word just read so that the next one can be collected.

Top module: `serial_word_ifreg`

## Requirements
- R1: After synchronous reset: word_o = 0, shift_cnt_o = 0, word_done_o = 0, ser_o = 0, and parity_o = 1.
- R2: A mode_set_i strobe latches acc_i[5] as the mode (0 = 12-bit wide, 1 = 8-bit narrow). It also clears the register, the shift count and parity_o (back to 1).
- R3: When dir_n_i = 1 (send), an xfer_i strobe loads acc_i into the register and zeroes the count. In narrow mode, bits 3:0 of the loaded word are zero.
- R4: When sending, ser_o shows the next outgoing bit: register bit 0 in wide mode and bit 4 in narrow mode. Each shift moves the register one place toward bit 0, so the word leaves lowest data bit first.
- R5: Each rising edge of shift_pulse_i causes exactly one shift, however long the pulse stays high. The shift takes effect on the third rising clock edge after the pulse goes high.
- R6: The count rises by one per shift up to 12 (wide) or 8 (narrow). At that value word_done_o = 1, and further pulses change neither the register nor the count.
- R7: When dir_n_i = 0 (receive), each shift puts ser_i into bit 11. After a full word, the first bit received is in bit 0 (wide) or in bit 4 (narrow). In narrow mode bits 3:0 of word_o stay zero.
- R8: parity_o is the odd parity of the data bits of the last loaded send word (all 12 bits in wide mode, bits 11:4 in narrow mode). It is set at load and does not change while the word shifts out.
- R9: Received bits are never parity-checked and never change parity_o.
- R10: When receiving, an xfer_i strobe clears the register and the count, ready for the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_set_i | input | 1 | Latch word mode from acc_i[5]; clear state |
| xfer_i | input | 1 | Send: load acc_i. Receive: release the word and clear |
| acc_i | input | 12 | Accumulator word |
| dir_n_i | input | 1 | 0 = peripheral to host, 1 = host to peripheral |
| shift_pulse_i | input | 1 | Asynchronous shift pulse from the peripheral |
| ser_i | input | 1 | Serial data from the peripheral |
| ser_o | output | 1 | Serial data to the peripheral |
| parity_o | output | 1 | Odd parity of the outgoing word |
| word_o | output | 12 | Parallel register contents for the host |
| shift_cnt_o | output | 4 | Shifts done on the current word |
| word_done_o | output | 1 | Count has reached the word length |

## Verification
Strobes (mode_set_i, xfer_i) take effect on the next rising edge. The bench drives them on a falling edge and samples on the following falling edge. A shift pulse passes two synchronizer flops and an edge flop, so its shift is due on the third rising edge after the pulse rises. The bench holds ser_i and the pulse for three full cycles before it samples, and a directed test confirms that nothing has changed after two edges. Parity and ser_o are read between shifts, when each should be stable.

// File: rtl/swr_pkg.sv
package swr_pkg;
   typedef enum logic {
      MODE_WIDE   = 1'b0,
      MODE_NARROW = 1'b1
   } word_mode_e;

   function automatic int unsigned word_len(input word_mode_e m,
                                            input int unsigned wide_w,
                                            input int unsigned narrow_w);
      return (m == MODE_NARROW) ? narrow_w : wide_w;
   endfunction
endpackage

// File: rtl/swr_edge_sync.sv
module swr_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES:0] pipe_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("swr_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= {pipe_q[STAGES-1:0], async_i};
   end

   assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/swr_shifter.sv
module swr_shifter
   import swr_pkg::*;
#(
   parameter int unsigned WORD_W   = 12,
   parameter int unsigned NARROW_W = 8,
   parameter int unsigned CNT_W    = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_data_i,
   input  logic              shift_i,
   input  logic              send_i,
   input  logic              ser_i,
   input  word_mode_e        mode_i,
   output logic [WORD_W-1:0] word_o,
   output logic              ser_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              full_o
);
   localparam int unsigned PAD = WORD_W - NARROW_W;
   localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(NARROW_W);

   logic [WORD_W-1:0] sr_q, shifted, loaded;
   logic [CNT_W-1:0]  cnt_q, len;
   logic              fill;

   assign len  = (mode_i == MODE_NARROW) ? LEN_NARROW : LEN_WIDE;
   assign fill = send_i ? 1'b0 : ser_i;

   always_comb begin
      shifted = {fill, sr_q[WORD_W-1:1]};
      loaded  = load_data_i;
      if (mode_i == MODE_NARROW) begin
         shifted[PAD-1:0] = '0;
         loaded[PAD-1:0]  = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clear_i) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         sr_q  <= loaded;
         cnt_q <= '0;
      end else if (shift_i && (cnt_q != len)) begin
         sr_q  <= shifted;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign word_o = sr_q;
   assign ser_o  = (mode_i == MODE_NARROW) ? sr_q[PAD] : sr_q[0];
   assign cnt_o  = cnt_q;
   assign full_o = (cnt_q == len);
endmodule

// File: rtl/swr_parity.sv
module swr_parity
   import swr_pkg::*;
#(
   parameter int unsigned WORD_W   = 12,
   parameter int unsigned NARROW_W = 8,
   parameter bit          ODD      = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] data_i,
   input  word_mode_e        mode_i,
   output logic              par_o
);
   localparam int unsigned PAD  = WORD_W - NARROW_W;
   localparam logic        IDLE = ODD;

   logic [WORD_W-1:0] bits;
   logic              xor_all, par_next, par_q;

   always_comb begin
      bits = data_i;
      if (mode_i == MODE_NARROW) bits[PAD-1:0] = '0;
   end

   assign xor_all = ^bits;

   generate
      if (ODD) begin : g_odd
         assign par_next = ~xor_all;
      end else begin : g_even
         assign par_next = xor_all;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clear_i) par_q <= IDLE;
      else if (load_i)    par_q <= par_next;
   end

   assign par_o = par_q;
endmodule

// File: rtl/serial_word_ifreg.sv
module serial_word_ifreg
   import swr_pkg::*;
#(
   parameter int unsigned WORD_W      = 12,
   parameter int unsigned NARROW_W    = 8,
   parameter int unsigned MODE_BIT    = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          ODD_PARITY  = 1'b1,
   localparam int unsigned CNT_W      = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_set_i,
   input  logic              xfer_i,
   input  logic [WORD_W-1:0] acc_i,
   input  logic              dir_n_i,
   input  logic              shift_pulse_i,
   input  logic              ser_i,
   output logic              ser_o,
   output logic              parity_o,
   output logic [WORD_W-1:0] word_o,
   output logic [CNT_W-1:0]  shift_cnt_o,
   output logic              word_done_o
);
   generate
      if (NARROW_W == 0 || NARROW_W >= WORD_W) begin : g_bad_narrow
         $error("serial_word_ifreg: NARROW_W must be in 1..WORD_W-1");
      end
      if (MODE_BIT >= WORD_W) begin : g_bad_mode_bit
         $error("serial_word_ifreg: MODE_BIT outside accumulator");
      end
   endgenerate

   word_mode_e mode_q;
   logic       shift_rise, send_load, recv_clear, clear_all;

   always_ff @(posedge clk) begin
      if (rst)             mode_q <= MODE_WIDE;
      else if (mode_set_i) mode_q <= word_mode_e'(acc_i[MODE_BIT]);
   end

   assign clear_all  = mode_set_i;
   assign send_load  = xfer_i & dir_n_i & ~mode_set_i;
   assign recv_clear = xfer_i & ~dir_n_i;

   swr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (shift_pulse_i),
      .rise_o  (shift_rise)
   );

   swr_shifter #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) u_shift (
      .clk         (clk),
      .rst         (rst),
      .clear_i     (clear_all | recv_clear),
      .load_i      (send_load),
      .load_data_i (acc_i),
      .shift_i     (shift_rise),
      .send_i      (dir_n_i),
      .ser_i       (ser_i),
      .mode_i      (mode_q),
      .word_o      (word_o),
      .ser_o       (ser_o),
      .cnt_o       (shift_cnt_o),
      .full_o      (word_done_o)
   );

   swr_parity #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .ODD(ODD_PARITY)) u_par (
      .clk     (clk),
      .rst     (rst),
      .clear_i (clear_all),
      .load_i  (send_load),
      .data_i  (acc_i),
      .mode_i  (mode_q),
      .par_o   (parity_o)
   );
endmodule

// File: rtl/swr_checker.sv
module swr_checker #(
   parameter int unsigned WORD_W   = 12,
   parameter int unsigned NARROW_W = 8,
   parameter int unsigned CNT_W    = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              mode_set_i,
   input logic              xfer_i,
   input logic              dir_n_i,
   input logic              narrow,
   input logic [WORD_W-1:0] word_o,
   input logic [CNT_W-1:0]  shift_cnt_o,
   input logic              word_done_o,
   input logic              parity_o
);
   localparam int unsigned PAD = WORD_W - NARROW_W;
   localparam logic [CNT_W-1:0] LEN_W = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] LEN_N = CNT_W'(NARROW_W);

   // R2: a mode change leaves a cleared count and register
   a_r2_mode_clears: assert property (@(posedge clk) disable iff (rst)
      mode_set_i |=> (shift_cnt_o == '0) && (word_o == '0));

   // R6: the count never passes the word length of the mode
   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      shift_cnt_o <= (narrow ? LEN_N : LEN_W));

   // R6: a full word is frozen until the next strobe
   a_r6_full_frozen: assert property (@(posedge clk) disable iff (rst)
      (word_done_o && !xfer_i && !mode_set_i) |=> $stable(word_o) && $stable(shift_cnt_o));

   // R5: the count moves by at most one per clock, or drops back to zero
   a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
      !$stable(shift_cnt_o) |-> (shift_cnt_o == '0) || (shift_cnt_o == $past(shift_cnt_o) + 1'b1));

   // R7: in narrow mode the low bits of the word stay zero
   a_r7_narrow_low_zero: assert property (@(posedge clk) disable iff (rst)
      narrow |-> (word_o[PAD-1:0] == '0));

   // R8 / R9: parity changes only on a send load or a mode change
   a_r8_parity_hold: assert property (@(posedge clk) disable iff (rst)
      !(mode_set_i || (xfer_i && dir_n_i)) |=> $stable(parity_o));
endmodule

bind serial_word_ifreg swr_checker #(
   .WORD_W(WORD_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .mode_set_i  (mode_set_i),
   .xfer_i      (xfer_i),
   .dir_n_i     (dir_n_i),
   .narrow      (mode_q == swr_pkg::MODE_NARROW),
   .word_o      (word_o),
   .shift_cnt_o (shift_cnt_o),
   .word_done_o (word_done_o),
   .parity_o    (parity_o)
);

// File: tb/tb_serial_word_ifreg.sv
module tb_serial_word_ifreg;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mode_set_i = 1'b0, xfer_i = 1'b0, dir_n_i = 1'b1;
   logic [11:0] acc_i = '0;
   logic        shift_pulse_i = 1'b0, ser_i = 1'b0;
   logic        ser_o, parity_o, word_done_o;
   logic [11:0] word_o;
   logic [3:0]  shift_cnt_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   serial_word_ifreg dut (
      .clk(clk), .rst(rst), .mode_set_i(mode_set_i), .xfer_i(xfer_i),
      .acc_i(acc_i), .dir_n_i(dir_n_i), .shift_pulse_i(shift_pulse_i),
      .ser_i(ser_i), .ser_o(ser_o), .parity_o(parity_o), .word_o(word_o),
      .shift_cnt_o(shift_cnt_o), .word_done_o(word_done_o)
   );

   // {send, narrow, data}
   localparam logic [13:0] VEC [7] = '{
      {1'b1, 1'b0, 12'hA5C},
      {1'b1, 1'b0, 12'h000},
      {1'b0, 1'b0, 12'h3C7},
      {1'b1, 1'b1, 12'hFFF},
      {1'b0, 1'b1, 12'h0B4},
      {1'b1, 1'b1, 12'h81F},
      {1'b0, 1'b0, 12'hFFF}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_mode(input bit narrow);
      @(negedge clk);
      acc_i      = narrow ? 12'h020 : 12'h000;
      mode_set_i = 1'b1;
      @(negedge clk);
      mode_set_i = 1'b0;
   endtask

   task automatic strobe(input logic [11:0] data);
      @(negedge clk);
      acc_i  = data;
      xfer_i = 1'b1;
      @(negedge clk);
      xfer_i = 1'b0;
   endtask

   task automatic pulse(input logic b);
      @(negedge clk);
      ser_i = b;
      shift_pulse_i = 1'b1;
      repeat (3) @(negedge clk);
      shift_pulse_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 word", {4'h0, word_o}, 16'h0000);
      chk("R1 cnt", {12'h0, shift_cnt_o}, 16'h0000);
      chk("R1 done", {15'h0, word_done_o}, 16'h0000);
      chk("R1 ser", {15'h0, ser_o}, 16'h0000);
      chk("R1 parity", {15'h0, parity_o}, 16'h0001);

      foreach (VEC[v]) begin
         automatic bit          send   = VEC[v][13];
         automatic bit          narrow = VEC[v][12];
         automatic logic [11:0] data   = VEC[v][11:0];
         automatic int          len    = narrow ? 8 : 12;
         automatic int          off    = 12 - len;
         automatic logic [11:0] masked = narrow ? (data & 12'hFF0) : data;
         automatic logic [11:0] rxexp  = (data & 12'((1 << len) - 1)) << off;
         dir_n_i = send;
         set_mode(narrow);
         chk("R2 cleared", {word_o, shift_cnt_o}, 16'h0000);
         if (send) begin
            strobe(data);
            chk("R3 load", {4'h0, word_o}, {4'h0, masked});
            chk("R8 parity", {15'h0, parity_o}, {15'h0, ~^masked});
            for (int k = 0; k < len; k++) begin
               chk("R4 serial bit", {15'h0, ser_o}, {15'h0, masked[off + k]});
               pulse(1'b1);
               chk("R8 parity held", {15'h0, parity_o}, {15'h0, ~^masked});
            end
         end else begin
            strobe(12'h000);
            for (int k = 0; k < len; k++) pulse(data[k]);
            chk("R7 rx word", {4'h0, word_o}, {4'h0, rxexp});
         end
         chk("R6 count", {11'h0, word_done_o, shift_cnt_o}, {11'h0, 1'b1, 4'(len)});
      end

      // R5 timing: no shift after two edges, shift on the third
      dir_n_i = 1'b1;
      set_mode(1'b0);
      strobe(12'h001);
      @(negedge clk);
      shift_pulse_i = 1'b1;
      repeat (2) @(negedge clk);
      chk("R5 not yet", {12'h0, shift_cnt_o}, 16'h0000);
      @(negedge clk);
      chk("R5 shifted", {12'h0, shift_cnt_o}, 16'h0001);
      // R5 long pulse shifts once
      repeat (10) @(negedge clk);
      chk("R5 long pulse", {12'h0, shift_cnt_o}, 16'h0001);
      shift_pulse_i = 1'b0;
      repeat (3) @(negedge clk);

      // R9: receiving leaves parity from the last send load (12'h001 -> 0)
      chk("R9 parity before", {15'h0, parity_o}, 16'h0000);
      dir_n_i = 1'b0;
      strobe(12'h000);
      chk("R10 rx clear", {word_o, shift_cnt_o}, 16'h0000);
      for (int k = 0; k < 5; k++) pulse(1'b1);
      chk("R9 parity unchanged", {15'h0, parity_o}, 16'h0000);
      chk("R7 partial", {4'h0, word_o}, 16'h0F80);
      strobe(12'h000);
      chk("R10 rx clear again", {word_o, shift_cnt_o}, 16'h0000);

      // R6: extra pulses after a full narrow word are ignored
      set_mode(1'b1);
      for (int k = 0; k < 8; k++) pulse(k[0]);
      chk("R6 narrow word", {4'h0, word_o}, 16'h0AA0);
      pulse(1'b1);
      pulse(1'b1);
      chk("R6 extra ignored", {4'h0, word_o}, 16'h0AA0);
      chk("R6 count held", {11'h0, word_done_o, shift_cnt_o}, 16'h0018);

      // R2: mode change clears parity to 1
      dir_n_i = 1'b1;
      strobe(12'h010);
      set_mode(1'b0);
      chk("R2 parity idle", {15'h0, parity_o}, 16'h0001);

      summary();
   end
endmodule